// File: doc/BRIEF.md
# Memory Command Sequencer Engine

A small programmable engine that replays a stored list of memory-bus commands onto one selected memory port. A host fills a 32-entry instruction store through a write interface. Each entry has two words: a command word and a control word. The command word holds the command bits, a logical rank and the clock-enable level. The control word holds the index of the next entry, an idle count, a repeat count and an end flag. The host chooses the target port through a configuration write and then pulses start.

Once started, the engine begins at entry 0. It issues the entry's command for one cycle. It then drives deselect for the idle count, repeats that pair as often as the repeat count says, and then jumps to the next index. Flow ends after an entry flagged as the end. The trailing idle period of that end entry is not waited out, so a program that needs a final wait appends a deselect entry that carries the end flag. An out-of-range next index aborts the run with an error flag. A stop input returns the engine to idle at any time.

Chip selects are formed per port in one of two modes. Direct mode drives two individual selects for two ranks. Encoded mode packs four ranks onto the two select lines plus a chip-id line.

Top module: `cmd_seq_engine`

## Requirements
- R1: Writes with wr_addr_i[5]=0 load the command word of entry wr_addr_i[4:0]. Writes with wr_addr_i[5]=1 load its control word. Any store write made while busy_o is high is ignored.
- R2: Command word layout: op [15:0], rank [17:16], cke [18]. Control word layout: next index [5:0], idle count [13:6], repeat count [17:14], end flag [18].
- R3: A start pulse accepted while idle raises busy_o and issues entry 0 in the following cycle. The done and error flags are cleared at the same time.
- R4: Each issue of an entry drives its op for exactly one cycle. The issue is followed by idle-count deselect cycles. The issue-and-idle pair occurs repeat+1 times in total.
- R5: After its final issue and idles, a non-end entry continues at its next index.
- R6: The final issue of an end-flagged entry has no trailing idle cycles. busy_o falls in the next cycle, and done_o is then set and held until the next accepted start.
- R7: If the next index is 32 or larger, the run terminates and err_o and done_o are both set.
- R8: When stop_i is high, the engine is idle in the next cycle without setting done_o. If stop_i coincides with start_i, the start is ignored and done_o and err_o keep their values.
- R9: While busy, port_en_o is the one-hot code of the port written through cfg_we_i/cfg_port_i. While idle it is zero. Port writes made while busy are ignored.
- R10: In direct mode (rank_mode_i[port]=0), rank 0 drives cs_n_o=2'b10 and rank 1 drives 2'b01. Ranks 2 and 3 drive 2'b11. cid_o is 0.
- R11: In encoded mode (rank_mode_i[port]=1), an issue drives cs_n_o={rank[0],1'b0} and cid_o=rank[1].
- R12: Outside issue cycles, cmd_o=0, cs_n_o=2'b11 and cid_o=0. cke_o holds the cke of the most recently issued entry, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Instruction store write strobe |
| wr_addr_i | input | 6 | Bit 5 selects control word, bits 4:0 entry index |
| wr_data_i | input | 19 | Word to store |
| cfg_we_i | input | 1 | Port-select write strobe |
| cfg_port_i | input | 2 | Port index to target |
| rank_mode_i | input | 4 | Per-port chip-select mode, 1 = encoded |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished |
| err_o | output | 1 | Last run hit an out-of-range index |
| port_en_o | output | 4 | One-hot active port |
| cmd_o | output | 16 | Command bits |
| cs_n_o | output | 2 | Active-low chip selects |
| cid_o | output | 1 | Chip id for encoded mode |
| cke_o | output | 1 | Clock enable |

## Verification
Start and stop can land in the same cycle. A stop raised while already idle together with a start must win, so busy_o stays low and the done and error flags from the previous run must survive. The bench provokes this right after a completed run, when done_o is high. It judges the result at the ports one cycle later. A second collision occurs when a store write and a port write arrive in the middle of a run. The bench judges this by comparing the rest of that run, and a later replay, against its model of the unchanged program.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int CMD_W   = 16;
  localparam int RANK_W  = 2;
  localparam int IDLE_W  = 8;
  localparam int RPT_W   = 4;
  localparam int NXT_W   = 6;
  localparam int WORD_W  = 19;

  typedef struct packed {
    logic              cke;
    logic [RANK_W-1:0] rank;
    logic [CMD_W-1:0]  op;
  } cmd_t;

  typedef struct packed {
    logic              end_f;
    logic [RPT_W-1:0]  rpt;
    logic [IDLE_W-1:0] idles;
    logic [NXT_W-1:0]  nxt;
  } ctl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
endpackage

// File: rtl/cse_store.sv
module cse_store
  import cse_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_ctl_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cmd_t             rd_cmd_o,
  output ctl_t             rd_ctl_o
);
  cmd_t [N_ENTRIES-1:0] cmd_mem;
  ctl_t [N_ENTRIES-1:0] ctl_mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_mem <= '0;
      ctl_mem <= '0;
    end else if (wr_en_i && !lock_i) begin
      if (wr_ctl_i) ctl_mem[wr_idx_i] <= ctl_t'(wr_data_i);
      else          cmd_mem[wr_idx_i] <= cmd_t'(wr_data_i);
    end
  end

  assign rd_cmd_o = cmd_mem[rd_idx_i];
  assign rd_ctl_o = ctl_mem[rd_idx_i];

  AST_STORE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_en_i) |=> ($stable(cmd_mem) && $stable(ctl_mem))); // R1
endmodule

// File: rtl/cse_cs_map.sv
module cse_cs_map
  import cse_pkg::*;
(
  input  logic              active_i,
  input  logic              encoded_i,
  input  logic [RANK_W-1:0] rank_i,
  output logic [1:0]        cs_n_o,
  output logic              cid_o
);
  always_comb begin
    cs_n_o = 2'b11;
    cid_o  = 1'b0;
    if (active_i) begin
      if (encoded_i) begin
        cs_n_o = {rank_i[0], 1'b0};
        cid_o  = rank_i[1];
      end else begin
        unique case (rank_i)
          2'd0:    cs_n_o = 2'b10;
          2'd1:    cs_n_o = 2'b01;
          default: cs_n_o = 2'b11;
        endcase
      end
    end
  end
endmodule

// File: rtl/cse_ctrl.sv
module cse_ctrl
  import cse_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int N_PORTS   = 4,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cfg_we_i,
  input  logic [PORT_W-1:0] cfg_port_i,
  input  cmd_t              cmd_i,
  input  ctl_t              ctl_i,
  output state_e            st_o,
  output logic [IDX_W-1:0]  pc_o,
  output logic [PORT_W-1:0] port_o,
  output logic              cke_o,
  output logic              done_o,
  output logic              err_o
);
  state_e            st_q, st_d;
  logic [IDX_W-1:0]  pc_q, pc_d;
  logic [RPT_W-1:0]  rpt_q, rpt_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              done_q, done_d, err_q, err_d, cke_q, cke_d;
  logic [PORT_W-1:0] port_q;
  logic              last_rpt, nxt_bad, adv;

  assign last_rpt = (rpt_q == ctl_i.rpt);
  assign nxt_bad  = (ctl_i.nxt >= NXT_W'(N_ENTRIES));

  always_comb begin
    st_d = st_q; pc_d = pc_q; rpt_d = rpt_q; idle_d = idle_q;
    done_d = done_q; err_d = err_q; cke_d = cke_q;
    adv = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_ISSUE; pc_d = '0; rpt_d = '0; done_d = 1'b0; err_d = 1'b0;
      end
      ST_ISSUE: begin
        cke_d = cmd_i.cke;
        if (ctl_i.end_f && last_rpt) begin
          st_d = ST_IDLE; done_d = 1'b1;        // trailing idles skipped
        end else if (ctl_i.idles != '0) begin
          st_d = ST_WAIT; idle_d = ctl_i.idles;
        end else adv = 1'b1;
      end
      ST_WAIT: begin
        if (idle_q == IDLE_W'(1)) adv = 1'b1;
        else idle_d = idle_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (adv) begin
      if (!last_rpt) begin
        rpt_d = rpt_q + 1'b1; st_d = ST_ISSUE;
      end else if (nxt_bad) begin
        err_d = 1'b1; done_d = 1'b1; st_d = ST_IDLE;
      end else begin
        pc_d = ctl_i.nxt[IDX_W-1:0]; rpt_d = '0; st_d = ST_ISSUE;
      end
    end
    if (stop_i) begin
      st_d = ST_IDLE; done_d = done_q; err_d = err_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; pc_q <= '0; rpt_q <= '0; idle_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; cke_q <= 1'b0; port_q <= '0;
    end else begin
      st_q <= st_d; pc_q <= pc_d; rpt_q <= rpt_d; idle_q <= idle_d;
      done_q <= done_d; err_q <= err_d; cke_q <= cke_d;
      if (cfg_we_i && st_q == ST_IDLE) port_q <= cfg_port_i;
    end
  end

  assign st_o = st_q;
  assign pc_o = pc_q;
  assign port_o = port_q;
  assign cke_o = cke_q;
  assign done_o = done_q;
  assign err_o = err_q;

  AST_START_ISSUES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && !stop_i) |=> (st_q == ST_ISSUE && pc_q == '0)); // R3
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE)); // R8
  AST_STOP_KEEPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(done_q)); // R8
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q == ST_IDLE)); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q); // R7
  AST_PORT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(port_q)); // R9
endmodule

// File: rtl/cmd_seq_engine.sv
module cmd_seq_engine
  import cse_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int N_PORTS   = 4,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W:0]     wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               cfg_we_i,
  input  logic [PORT_W-1:0]  cfg_port_i,
  input  logic [N_PORTS-1:0] rank_mode_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [N_PORTS-1:0] port_en_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [1:0]         cs_n_o,
  output logic               cid_o,
  output logic               cke_o
);
  cmd_t              cur_cmd;
  ctl_t              cur_ctl;
  state_e            st;
  logic [IDX_W-1:0]  pc;
  logic [PORT_W-1:0] port;
  logic              cke_hold, issuing;

  cse_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_ctl_i (wr_addr_i[IDX_W]),
    .wr_idx_i (wr_addr_i[IDX_W-1:0]),
    .wr_data_i,
    .lock_i   (busy_o),
    .rd_idx_i (pc),
    .rd_cmd_o (cur_cmd),
    .rd_ctl_o (cur_ctl)
  );

  cse_ctrl #(.N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .cfg_we_i, .cfg_port_i,
    .cmd_i (cur_cmd), .ctl_i (cur_ctl),
    .st_o (st), .pc_o (pc), .port_o (port), .cke_o (cke_hold),
    .done_o, .err_o
  );

  assign issuing = (st == ST_ISSUE);
  assign busy_o  = (st != ST_IDLE);
  assign cmd_o   = issuing ? cur_cmd.op : '0;
  assign cke_o   = issuing ? cur_cmd.cke : cke_hold;

  cse_cs_map u_cs (
    .active_i  (issuing),
    .encoded_i (rank_mode_i[port]),
    .rank_i    (cur_cmd.rank),
    .cs_n_o, .cid_o
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port_en
    assign port_en_o[p] = busy_o && (port == PORT_W'(p));
  end

  AST_PORT_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(port_en_o) == 1)); // R9
  AST_PORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (port_en_o == '0)); // R9
  AST_DESELECT_OFF_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issuing |-> (cs_n_o == 2'b11 && !cid_o && cmd_o == '0)); // R12
  AST_CKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issuing && $past(!issuing) && !$past(stop_i)) |-> $stable(cke_o)); // R12
endmodule

// File: tb/cmd_seq_engine_tb_top.sv
module cmd_seq_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        busy;
    logic [15:0] cmd;
    logic [1:0]  cs_n;
    logic        cid;
    logic        cke;
    logic [3:0]  pen;
  } exp_t;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, cfg_we_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [18:0] wr_data_i = '0;
  logic [1:0]  cfg_port_i = '0;
  logic [3:0]  rank_mode_i = 4'b0010;
  logic        busy_o, done_o, err_o, cid_o, cke_o;
  logic [3:0]  port_en_o;
  logic [15:0] cmd_o;
  logic [1:0]  cs_n_o;

  int n_chk = 0, n_fail = 0;
  int m_cmd [32];
  int m_ctl [32];
  exp_t q[$];
  bit   e_err;
  logic cke_last = 1'b0;

  cmd_seq_engine dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic check(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic string fmt(logic b, logic [15:0] c, logic [1:0] s, logic d, logic k, logic [3:0] p);
    return $sformatf("busy=%0b cmd=%h cs_n=%b cid=%0b cke=%0b pen=%b", b, c, s, d, k, p);
  endfunction

  task automatic cmp(exp_t e, string req);
    check(busy_o === e.busy && cmd_o === e.cmd && cs_n_o === e.cs_n && cid_o === e.cid &&
          cke_o === e.cke && port_en_o === e.pen, req,
          fmt(busy_o, cmd_o, cs_n_o, cid_o, cke_o, port_en_o),
          fmt(e.busy, e.cmd, e.cs_n, e.cid, e.cke, e.pen));
  endtask

  // R1 R2: bench mirror updated only for writes made while idle
  task automatic wr(bit ctl, int idx, int data);
    wr_en_i = 1'b1; wr_addr_i = {ctl, 5'(idx)}; wr_data_i = 19'(data);
    @(posedge clk_i); #1 wr_en_i = 1'b0;
    if (ctl) m_ctl[idx] = data; else m_cmd[idx] = data;
  endtask

  function automatic int cw(int op, int rank, int cke);
    return (cke << 18) | (rank << 16) | op;
  endfunction
  function automatic int kw(int nxt, int idles, int rpt, int e);
    return (e << 18) | (rpt << 14) | (idles << 6) | nxt;
  endfunction

  task automatic set_port(int p);
    cfg_we_i = 1'b1; cfg_port_i = 2'(p);
    @(posedge clk_i); #1 cfg_we_i = 1'b0;
  endtask

  // Behavioural walk of the program: R4 R5 R6 R7 R10 R11 R12
  task automatic build(int port);
    int pc = 0, guard = 0;
    bit enc = rank_mode_i[port];
    logic [3:0] pen = 4'(1 << port);
    q.delete(); e_err = 0;
    forever begin
      int op = m_cmd[pc] & 16'hFFFF, rank = (m_cmd[pc] >> 16) & 3, ck = (m_cmd[pc] >> 18) & 1;
      int nxt = m_ctl[pc] & 63, idl = (m_ctl[pc] >> 6) & 255;
      int rpt = (m_ctl[pc] >> 14) & 15, en = (m_ctl[pc] >> 18) & 1;
      for (int r = 0; r <= rpt; r++) begin
        exp_t e;
        e.busy = 1; e.cmd = 16'(op); e.cke = ck[0]; e.pen = pen;
        if (enc) begin e.cs_n = {rank[0], 1'b0}; e.cid = rank[1]; end
        else begin
          e.cid = 0;
          e.cs_n = (rank == 0) ? 2'b10 : (rank == 1) ? 2'b01 : 2'b11;
        end
        q.push_back(e);
        cke_last = ck[0];
        if (!(en == 1 && r == rpt))
          for (int i = 0; i < idl; i++) begin
            exp_t d;
            d.busy = 1; d.cmd = 0; d.cs_n = 2'b11; d.cid = 0; d.cke = ck[0]; d.pen = pen;
            q.push_back(d);
          end
      end
      if (en == 1) break;
      if (nxt >= 32) begin e_err = 1; break; end
      pc = nxt;
      guard++;
      if (guard > 500) break;
    end
  endtask

  // stop_at >= 0: raise stop after that cycle; poke_at >= 0: write store and port mid-run
  task automatic run(int port, string req, int stop_at, int poke_at);
    build(port);
    start_i = 1'b1; @(posedge clk_i); #1 start_i = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk_i);
      cmp(q[i], req);
      if (i == poke_at) begin
        wr_en_i = 1'b1; wr_addr_i = 6'd0; wr_data_i = 19'h7_ABCD;
        cfg_we_i = 1'b1; cfg_port_i = 2'(port ^ 1);
        @(posedge clk_i); #1 wr_en_i = 1'b0; cfg_we_i = 1'b0;
      end
      if (i == stop_at) begin
        stop_i = 1'b1; @(posedge clk_i); #1 stop_i = 1'b0;
        @(negedge clk_i);
        check(!busy_o && !done_o && port_en_o == 4'b0, "R8 stop mid-run",
              $sformatf("busy=%0b done=%0b pen=%b", busy_o, done_o, port_en_o), "busy=0 done=0 pen=0000");
        return;
      end
    end
    @(negedge clk_i);
    begin
      exp_t e;
      e.busy = 0; e.cmd = 0; e.cs_n = 2'b11; e.cid = 0; e.cke = cke_last; e.pen = 0;
      cmp(e, {req, " R6 R12 end-idle"});
    end
    check(done_o === 1'b1 && err_o === e_err, e_err ? "R7 err flag" : "R6 done flag",
          $sformatf("done=%0b err=%0b", done_o, err_o), $sformatf("done=1 err=%0b", e_err));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_cmd[i] = 0; m_ctl[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !err_o && cs_n_o == 2'b11 && !cke_o && port_en_o == 0 && cmd_o == 0,
          "R12 reset state", fmt(busy_o, cmd_o, cs_n_o, cid_o, cke_o, port_en_o), "idle, cke=0");

    // Program A, direct port 2: idles, repeats, end entry with skipped idles
    wr(0, 0, cw(16'h1111, 0, 1)); wr(1, 0, kw(1, 2, 0, 0));
    wr(0, 1, cw(16'h2222, 1, 1)); wr(1, 1, kw(2, 0, 2, 0));
    wr(0, 2, cw(16'h3333, 2, 1)); wr(1, 2, kw(3, 1, 1, 0));
    wr(0, 3, cw(16'h0000, 3, 0)); wr(1, 3, kw(4, 3, 0, 1));
    set_port(2);
    @(negedge clk_i);
    run(2, "R3 R4 R10 prog A", -1, -1);

    // start and stop together while idle with done high
    @(negedge clk_i);
    start_i = 1'b1; stop_i = 1'b1; @(posedge clk_i); #1 begin start_i = 1'b0; stop_i = 1'b0; end
    @(negedge clk_i);
    check(!busy_o && done_o, "R8 start+stop", $sformatf("busy=%0b done=%0b", busy_o, done_o), "busy=0 done=1");

    // Program B, encoded port 1: goto jumps, repeats on end entry
    wr(0, 0, cw(16'hA0A0, 1, 1)); wr(1, 0, kw(5, 0, 0, 0));
    wr(0, 5, cw(16'hB5B5, 2, 0)); wr(1, 5, kw(3, 1, 1, 0));
    wr(0, 3, cw(16'hC3C3, 3, 1)); wr(1, 3, kw(0, 2, 1, 1));
    set_port(1);
    @(negedge clk_i);
    run(1, "R5 R11 prog B", -1, -1);

    // writes during a run must be ignored; replay must match mirror
    run(1, "R1 R9 busy writes", -1, 1);
    @(negedge clk_i);
    run(1, "R1 replay after busy writes", -1, -1);

    // stop mid-run
    @(negedge clk_i);
    run(1, "R8 pre-stop", 2, -1);

    // out-of-range next index, direct port 0
    wr(0, 0, cw(16'h5555, 0, 1)); wr(1, 0, kw(40, 1, 0, 0));
    set_port(0);
    @(negedge clk_i);
    run(0, "R7 bad next", -1, -1);

    // new start clears done and err
    @(negedge clk_i);
    start_i = 1'b1; @(posedge clk_i); #1 start_i = 1'b0;
    @(negedge clk_i);
    check(busy_o && !done_o && !err_o && cmd_o == 16'h5555, "R3 start clears flags",
          $sformatf("busy=%0b done=%0b err=%0b cmd=%h", busy_o, done_o, err_o, cmd_o), "busy=1 done=0 err=0 cmd=5555");
    repeat (4) @(negedge clk_i);

    summary();
    $finish;
  end
endmodule